// File: doc/BRIEF.md
# Daisy-Chain Serial Word Router

This block is the serial-port logic of one channel in a chain of codec channels that share a single host link. Words of 16 bits arrive MSB first on a serial input and are framed by a one-clock input frame sync. Each complete word is classified either as DAC sample data or as a control word. Control words carry a 3-bit hop address. A word whose address has reached zero belongs to this channel: it either writes one of three local 8-bit configuration registers or requests that register's contents back. Every other word is sent on downstream with a fresh output frame sync. Forwarded control words leave with their address lowered by one.

The output frame sync of one channel feeds the input frame sync of the next, so a host reaches the channel N hops away by sending address N. Readback words travel back through the remaining channels in the same way, and each hop decrements their address field. A counter of DAC-carrying frame syncs, compared against a chain-length field in configuration register A, decides when a received DAC word is copied to the DAC output.

Top module: `cwr_channel`

## Requirements
- R1: A word is received over 16 clocks, MSB first. The input frame sync is high in the clock of its first bit. A frame sync that arrives before a word is complete discards the partial word and starts a new one.
- R2: Register A bit 3 selects mixed mode and bit 4 selects program mode. In mixed mode, a word with bit 15 = 1 is control and a word with bit 15 = 0 is DAC data. Outside mixed mode, every word is control when program mode is set and every word is DAC data when it is clear. After reset, register A = 0x11, so all words are control.
- R3: A control word with address bits 13:11 = 000 is local. If bit 14 = 0, it writes data bits 7:0 into the register chosen by bits 10:8 (0 = A, 1 = B, 2 = C), and selects 3 to 7 write nothing. A local write produces no output frame.
- R4: A local control word with bit 14 = 1 produces the output word {1, 1, 111, select, contents}. An unimplemented select returns contents 0x00.
- R5: A control word that is not local is forwarded with bits 13:11 decremented by one and every other bit unchanged.
- R6: DAC data words are forwarded unchanged.
- R7: Every output word is sent MSB first over 16 clocks. The output frame sync is high for exactly the clock that carries the MSB. The serial output is 0 when idle.
- R8: Register A bits 2:0 give the chain length L, where 0 counts as 1. Each DAC word advances a counter. The DAC word that brings the count to L is copied whole to the DAC output, and the counter clears. Control words do not advance the counter.
- R9: The DAC output is 0 after reset and keeps its value between updates. Registers B and C are 0 after reset, and the output frame sync is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data in, MSB first |
| fs_in | input | 1 | Input frame sync, high with the first bit |
| ser_out | output | 1 | Serial data out toward the next channel |
| fs_out | output | 1 | Output frame sync, high with the MSB |
| dac_word | output | 16 | Latched DAC output register |

## Verification
Take E as the clock edge that samples the last bit of an input word. The word is registered at E, and its register write, DAC update and output load all take effect at the next edge. The output frame sync is therefore first visible in the clock after that second edge, and the 16 output bits follow in consecutive clocks. The bench captures output frames on falling edges from the frame sync onward. It checks a result only after an idle gap of 20 clocks that follows each sent word, which is longer than the full two-edge latency plus the 16-bit output frame. Register contents are checked only through readback words seen at the serial output.

// File: rtl/cwr_pkg.sv
`timescale 1ns/1ps
package cwr_pkg;
    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int SEL_W   = 3;
    localparam int DATA_W  = 8;
    localparam int NREGS   = 3;
    localparam int BIT_W   = $clog2(WORD_W);

    // register A field positions
    localparam int A_CNT_LSB = 0;
    localparam int A_MIXED   = 3;
    localparam int A_PROG    = 4;

    typedef struct packed {
        logic              is_ctl;
        logic              rdbk;
        logic [ADDR_W-1:0] addr;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] data;
    } ctl_word_t;

    function automatic logic [DATA_W-1:0] reg_reset(input int idx);
        return (idx == 0) ? DATA_W'(8'h11) : '0;
    endfunction

    function automatic ctl_word_t hop(input ctl_word_t w);
        ctl_word_t r;
        r      = w;
        r.addr = w.addr - ADDR_W'(1);
        return r;
    endfunction

    function automatic logic classify_ctl(input logic msb, input logic mixed, input logic prog);
        return mixed ? msb : prog;
    endfunction
endpackage

// File: rtl/cwr_rx.sv
`timescale 1ns/1ps
module cwr_rx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_i,
    input  logic         fs_i,
    output logic [W-1:0] word_o,
    output logic         done_o
);
    localparam int IW = $clog2(W);

    logic [W-1:0]  sh;
    logic [IW-1:0] idx;
    logic          busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            idx    <= '0;
            busy   <= 1'b0;
            done_o <= 1'b0;
            word_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (fs_i) begin
                sh   <= {{(W-1){1'b0}}, ser_i};
                idx  <= IW'(1);
                busy <= 1'b1;
            end else if (busy) begin
                sh <= {sh[W-2:0], ser_i};
                if (idx == IW'(W-1)) begin
                    word_o <= {sh[W-2:0], ser_i};
                    done_o <= 1'b1;
                    busy   <= 1'b0;
                    idx    <= '0;
                end else begin
                    idx <= idx + IW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/cwr_tx.sv
`timescale 1ns/1ps
module cwr_tx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    output logic         ser_o,
    output logic         fs_o
);
    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            fs_o <= 1'b0;
        end else if (load_i) begin
            sh   <= word_i;
            fs_o <= 1'b1;
        end else begin
            sh   <= {sh[W-2:0], 1'b0};
            fs_o <= 1'b0;
        end
    end

    assign ser_o = sh[W-1];
endmodule

// File: rtl/cwr_dac_sync.sv
`timescale 1ns/1ps
module cwr_dac_sync #(
    parameter int W  = 16,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic [W-1:0]  word_i,
    input  logic [CW-1:0] limit_i,
    output logic [W-1:0]  dac_o,
    output logic [CW-1:0] cnt_o
);
    logic [CW:0] nxt;
    logic [CW:0] lim_eff;

    always_comb begin
        nxt     = {1'b0, cnt_o} + (CW+1)'(1);
        lim_eff = (limit_i == '0) ? (CW+1)'(1) : {1'b0, limit_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
            dac_o <= '0;
        end else if (tick_i) begin
            if (nxt >= lim_eff) begin
                dac_o <= word_i;
                cnt_o <= '0;
            end else begin
                cnt_o <= nxt[CW-1:0];
            end
        end
    end
endmodule

// File: rtl/cwr_channel.sv
`timescale 1ns/1ps
module cwr_channel
    import cwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              fs_in,
    output logic              ser_out,
    output logic              fs_out,
    output logic [WORD_W-1:0] dac_word
);
    logic [WORD_W-1:0] rx_word;
    logic              rx_done;
    logic [DATA_W-1:0] regs [NREGS];
    logic [ADDR_W-1:0] dac_cnt;

    ctl_word_t         cw;
    logic              mixed, prog, is_ctl, is_local, do_write;
    logic              tx_load;
    logic [WORD_W-1:0] tx_word;
    logic [DATA_W-1:0] rd_data;
    ctl_word_t         rb_word;

    cwr_rx #(.W(WORD_W)) u_rx (
        .clk(clk), .rst(rst), .ser_i(ser_in), .fs_i(fs_in),
        .word_o(rx_word), .done_o(rx_done)
    );

    always_comb begin
        cw       = ctl_word_t'(rx_word);
        mixed    = regs[0][A_MIXED];
        prog     = regs[0][A_PROG];
        is_ctl   = classify_ctl(cw.is_ctl, mixed, prog);
        is_local = is_ctl && (cw.addr == '0);
        do_write = rx_done && is_local && !cw.rdbk;

        rd_data = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (cw.sel == SEL_W'(i)) rd_data = regs[i];
        end

        rb_word        = cw;
        rb_word.is_ctl = 1'b1;
        rb_word.rdbk   = 1'b1;
        rb_word.addr   = '1;
        rb_word.data   = rd_data;

        tx_load = rx_done && !(is_local && !cw.rdbk);
        if (!is_ctl)       tx_word = rx_word;
        else if (is_local) tx_word = rb_word;
        else               tx_word = hop(cw);
    end

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= reg_reset(g);
            else if (do_write && cw.sel == SEL_W'(g))
                regs[g] <= cw.data;
        end
    end

    cwr_tx #(.W(WORD_W)) u_tx (
        .clk(clk), .rst(rst), .load_i(tx_load), .word_i(tx_word),
        .ser_o(ser_out), .fs_o(fs_out)
    );

    cwr_dac_sync #(.W(WORD_W), .CW(ADDR_W)) u_dac (
        .clk(clk), .rst(rst), .tick_i(rx_done && !is_ctl), .word_i(rx_word),
        .limit_i(regs[0][A_CNT_LSB +: ADDR_W]), .dac_o(dac_word), .cnt_o(dac_cnt)
    );
endmodule

// File: rtl/cwr_channel_chk.sv
`timescale 1ns/1ps
module cwr_channel_chk (
    input logic        clk,
    input logic        rst,
    input logic        fs_out,
    input logic        rx_done,
    input logic [15:0] dac_word,
    input logic [2:0]  dac_cnt
);
    // R7: output frame sync lasts one clock
    a_r7_fs_single: assert property (@(posedge clk) disable iff (rst)
        fs_out |=> !fs_out);

    // R7: an output frame only follows a completed input word
    a_r7_fs_after_word: assert property (@(posedge clk) disable iff (rst)
        fs_out |-> $past(rx_done));

    // R9: the DAC output changes only after a completed word
    a_r9_dac_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_word) |-> $past(rx_done));

    // R8: a DAC update clears the frame counter
    a_r8_cnt_clear: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_word) |-> dac_cnt == 3'd0);
endmodule

bind cwr_channel cwr_channel_chk u_chk (
    .clk(clk), .rst(rst), .fs_out(fs_out), .rx_done(rx_done),
    .dac_word(dac_word), .dac_cnt(dac_cnt)
);

// File: tb/test_cwr_channel.sv
`timescale 1ns/1ps
module test_cwr_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_in = 1'b0;
    logic        fs_in = 1'b0;
    logic        ser_out, fs_out;
    logic [15:0] dac_word;

    int checks = 0;
    int failures = 0;
    int frames = 0;
    int nbit = 0;
    logic [15:0] cur = '0;
    logic [15:0] last = '0;
    bit finished = 0;

    always #5 clk = ~clk;

    cwr_channel i_cwr_channel (
        .clk(clk), .rst(rst), .ser_in(ser_in), .fs_in(fs_in),
        .ser_out(ser_out), .fs_out(fs_out), .dac_word(dac_word)
    );

    // capture output frames on falling edges
    always @(negedge clk) begin
        if (fs_out) begin
            cur  = {15'b0, ser_out};
            nbit = 1;
        end else if (nbit > 0 && nbit < 16) begin
            cur  = {cur[14:0], ser_out};
            nbit = nbit + 1;
            if (nbit == 16) begin
                last   = cur;
                frames = frames + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        for (int b = 15; b >= 0; b--) begin
            @(negedge clk);
            fs_in  = (b == 15);
            ser_in = w[b];
        end
        @(negedge clk);
        fs_in  = 1'b0;
        ser_in = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    function automatic logic [15:0] fwd(input logic [15:0] w);
        return {w[15:14], w[13:11] - 3'd1, w[10:0]};
    endfunction

    function automatic logic [15:0] rbw(input logic [2:0] sel, input logic [7:0] d);
        return {2'b11, 3'b111, sel, d};
    endfunction

    // send a word and expect one output frame
    task automatic send_exp(input string req, input logic [15:0] w, input logic [15:0] exp);
        int f0;
        f0 = frames;
        send(w);
        check(req, frames - f0, 1);
        check(req, last, exp);
    endtask

    task automatic send_none(input string req, input logic [15:0] w);
        int f0;
        f0 = frames;
        send(w);
        check(req, frames - f0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 fs_out reset", fs_out, 0);
        check("R9 ser_out idle", ser_out, 0);
        check("R9 dac reset", dac_word, 0);

        // R2 R4 reset value of A read back; R7 frame shape
        send_exp("R4 readback A", 16'hC000, rbw(3'd0, 8'h11));
        send_exp("R9 readback B", 16'hC100, rbw(3'd1, 8'h00));
        send_exp("R9 readback C", 16'hC200, rbw(3'd2, 8'h00));
        check("R7 idle after frame", ser_out, 0);

        // R5 sweep of non-local control words
        for (int a = 1; a < 8; a++)
            for (int r = 0; r < 2; r++)
                for (int s = 0; s < 4; s++) begin
                    logic [15:0] w;
                    w = {1'b1, r[0], a[2:0], s[2:0], 8'(a * 16 + s)};
                    send_exp("R5 forward decrement", w, fwd(w));
                end
        send_exp("R5 no write on forward", 16'hC100, rbw(3'd1, 8'h00));

        // R3 local writes
        send_none("R3 write B no frame", 16'h815A);
        send_exp("R3 readback B", 16'hC100, rbw(3'd1, 8'h5A));
        send_none("R3 write C no frame", 16'h82C3);
        send_exp("R3 readback C", 16'hC200, rbw(3'd2, 8'hC3));
        send_none("R3 write sel5 ignored", 16'h8577);
        send_exp("R4 readback sel5 zero", 16'hC500, rbw(3'd5, 8'h00));
        send_exp("R3 sel5 left A", 16'hC000, rbw(3'd0, 8'h11));

        // R2 program mode: MSB 0 still a control word
        send_exp("R2 prog MSB0 is control", 16'h4100, rbw(3'd1, 8'h5A));
        check("R2 no dac in prog", dac_word, 0);

        // R10-type layout in R2/R8: A = mixed, count 3
        send_none("R2 write A mixed", 16'h800B);
        send_exp("R2 readback A", 16'hC000, rbw(3'd0, 8'h0B));

        // R6 R8 counting DAC frames
        send_exp("R6 dac fwd 1", 16'h1234, 16'h1234);
        check("R8 no update 1/3", dac_word, 0);
        send_exp("R8 ctl not counted", 16'hD100, 16'hC900);
        send_exp("R6 dac fwd 2", 16'h2345, 16'h2345);
        check("R8 no update 2/3", dac_word, 0);
        send_exp("R6 dac fwd 3", 16'h3456, 16'h3456);
        check("R8 update at 3", dac_word, 16'h3456);
        send(16'h0111);
        check("R9 hold after 1", dac_word, 16'h3456);
        send(16'h0222);
        check("R9 hold after 2", dac_word, 16'h3456);
        send(16'h0333);
        check("R8 second update", dac_word, 16'h0333);

        // R8 count field 0 behaves as 1
        send_none("R8 write A count0", 16'h8008);
        send(16'h0ABC);
        check("R8 count0 updates each word", dac_word, 16'h0ABC);

        // R1 partial word discarded by new frame sync
        begin
            int f0;
            f0 = frames;
            for (int b = 0; b < 5; b++) begin
                @(negedge clk);
                fs_in  = (b == 0);
                ser_in = 1'b1;
            end
            send(16'h0DEF);
            check("R1 restart one frame", frames - f0, 1);
            check("R1 restart word", last, 16'h0DEF);
            check("R1 restart dac", dac_word, 16'h0DEF);
        end

        // R2 data mode: every word is DAC data
        send_none("R2 write A data mode", 16'h8001);
        send_exp("R2 data mode MSB1 fwd", 16'hC123, 16'hC123);
        check("R2 data mode MSB1 dac", dac_word, 16'hC123);
        send_exp("R2 data mode ctl-like", 16'h8000, 16'h8000);
        check("R2 data mode no write", dac_word, 16'h8000);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule